// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block keeps one pending flag for each of fourteen asynchronous interrupt sources of a processor core. A source raises its flag with a one-cycle set strobe, and a source that holds its request as a level can withdraw it with a clear strobe. When the core asks for an evaluation, the arbiter looks at every pending flag the current machine state allows and picks one winner. The choice follows a fixed ranking. One clock later it reports the winner as a single-cycle take pulse with a four-bit cause code.

Each source has its own rule for whether a take consumes its flag. Most sources are cleared as they are taken. The hypervisor decrementer is never cleared by a take. The decrementer is cleared only when clear-on-take is configured. The critical external and external inputs can be set to stay pending because the requester holds them as levels. A summary output tells the core that work is still pending. It stays high until the whole pending register is empty.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after it, all pending flags are zero, take is 0 and hard_irq is 0.
- R2: A set strobe on req_set[i] makes flag i pending from the next clock edge. It wins over a req_clr on the same bit and over a consuming take of the same bit in the same cycle.
- R3: Cause codes follow the priority ranking, 0 being highest: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal. The req_set and req_clr bits use the same index. If eval_en is high in cycle t, take is 1 in cycle t+1 and take_cause is the lowest-numbered source that is both pending and eligible. If no source qualifies, take is 0.
- R4: Machine check (1) is eligible only while mchk_en is 1. Otherwise it stays pending.
- R5: The hypervisor decrementer (3) is eligible only when hyp_dec_en is 1 and at least one of these holds: ee_en is 1, hyp_mode is 0, or prob_state is 1. Its flag is never cleared by a take.
- R6: Sources 4 to 13 are eligible only while ee_en is 1. Sources 4, 5 and 6 also need crit_en to be 1.
- R7: Taking source 0, 1, 2, 5, 6, 7, 8, 11, 12 or 13 clears its flag.
- R8: Taking the decrementer (9) clears its flag only while dec_clr_on_take is 1.
- R9: Taking critical external (4) or external (10) leaves the flag set while cext_hold or ext_hold, respectively, is 1. Otherwise the take clears it.
- R10: req_clr[i] without req_set[i] clears flag i at the next edge.
- R11: hard_irq is 1 exactly while at least one pending flag is set. It drops in the cycle the register reads zero.
- R12: At most one take is reported per cycle. take is 1 only in the cycle after eval_en was 1, and it lasts one cycle for each evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 14 | Per-source set strobes, indexed by cause code |
| req_clr | input | 14 | Per-source withdrawal strobes, indexed by cause code |
| eval_en | input | 1 | Run an arbitration this cycle |
| ee_en | input | 1 | External interrupt enable from machine state |
| crit_en | input | 1 | Critical interrupt enable |
| mchk_en | input | 1 | Machine check enable |
| hyp_mode | input | 1 | Core is in hypervisor mode |
| prob_state | input | 1 | Core is in problem (user) state |
| hyp_dec_en | input | 1 | Enable bit of the partition control word for the hypervisor decrementer |
| dec_clr_on_take | input | 1 | Decrementer flag is consumed on take |
| cext_hold | input | 1 | Critical external flag survives a take |
| ext_hold | input | 1 | External flag survives a take |
| take | output | 1 | One-cycle take pulse |
| take_cause | output | 4 | Cause code of the taken source |
| hard_irq | output | 1 | Some flag is still pending |

## Verification
On every cycle, the embedded properties check the gating of each take against the enables of the previous cycle. They check that the winner was pending, that set beats clear, that withdrawals work, and the per-source consume or keep rules for the hypervisor decrementer, the decrementer and the always-consumed sources. Only the bench scenarios can show that the winner is the highest-ranked eligible source when several compete. The scenarios also show that a held source is taken again on the next evaluation, and that the summary output falls in the exact cycle the last flag goes away.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
   localparam int NSRC    = 14;
   localparam int CAUSE_W = $clog2(NSRC);

   // Source indices; lower index means higher priority.
   localparam int IDX_RST   = 0;
   localparam int IDX_MCHK  = 1;
   localparam int IDX_DBG   = 2;
   localparam int IDX_HDEC  = 3;
   localparam int IDX_CEXT  = 4;
   localparam int IDX_WDOG  = 5;
   localparam int IDX_CDB   = 6;
   localparam int IDX_FIT   = 7;
   localparam int IDX_PIT   = 8;
   localparam int IDX_DEC   = 9;
   localparam int IDX_EXT   = 10;
   localparam int IDX_DB    = 11;
   localparam int IDX_PERF  = 12;
   localparam int IDX_THERM = 13;

   // Sources whose flag is consumed on every take, whatever the configuration.
   function automatic logic always_consumed(input int idx);
      return !(idx == IDX_HDEC || idx == IDX_DEC ||
               idx == IDX_CEXT || idx == IDX_EXT);
   endfunction
endpackage

// File: rtl/irqarb_pend.sv
module irqarb_pend #(
   parameter int N = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_q
);
   if (N < 1) begin : g_chk_n
      $error("irqarb_pend: N must be at least 1");
   end

   logic [N-1:0] pend_d;

   // A set request overrides any clear of the same bit.
   always_comb pend_d = (pend_q & ~clr_i) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   // R2: a strobe seen last cycle must have left its flag pending
   p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(set_i) & ~pend_q) == '0));

   // R10: a withdrawal without a set leaves the flag clear
   p_withdraw_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irqarb_gate.sv
module irqarb_gate
   import irqarb_pkg::*;
(
   input  logic            ee_en,
   input  logic            crit_en,
   input  logic            mchk_en,
   input  logic            hyp_mode,
   input  logic            prob_state,
   input  logic            hyp_dec_en,
   output logic [NSRC-1:0] elig
);
   logic hdec_ok;
   assign hdec_ok = hyp_dec_en & (ee_en | ~hyp_mode | prob_state);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == IDX_RST || i == IDX_DBG) begin : g_free
         assign elig[i] = 1'b1;
      end else if (i == IDX_MCHK) begin : g_mchk
         assign elig[i] = mchk_en;
      end else if (i == IDX_HDEC) begin : g_hdec
         assign elig[i] = hdec_ok;
      end else if (i == IDX_CEXT || i == IDX_WDOG || i == IDX_CDB) begin : g_crit
         assign elig[i] = ee_en & crit_en;
      end else begin : g_ext
         assign elig[i] = ee_en;
      end
   end
endmodule

// File: rtl/irqarb_pick.sv
module irqarb_pick #(
   parameter int N     = 14,
   parameter int STYLE = 0,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          valid,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   if (STYLE != 0 && STYLE != 1) begin : g_chk_style
      $error("irqarb_pick: STYLE must be 0 or 1");
   end

   assign valid = |req;

   if (STYLE == 0) begin : g_scan
      // Scan from lowest priority up so the lowest index wins.
      always_comb begin
         idx    = '0;
         onehot = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               idx    = IW'(i);
               onehot = N'(1) << i;
            end
         end
      end
   end else begin : g_isolate
      // Isolate the lowest set bit, then encode it.
      assign onehot = req & (~req + N'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irqarb_pkg::*;
#(
   parameter int PICK_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC-1:0]    req_set,
   input  logic [NSRC-1:0]    req_clr,
   input  logic               eval_en,
   input  logic               ee_en,
   input  logic               crit_en,
   input  logic               mchk_en,
   input  logic               hyp_mode,
   input  logic               prob_state,
   input  logic               hyp_dec_en,
   input  logic               dec_clr_on_take,
   input  logic               cext_hold,
   input  logic               ext_hold,
   output logic               take,
   output logic [CAUSE_W-1:0] take_cause,
   output logic               hard_irq
);
   logic [NSRC-1:0]    pend_q;
   logic [NSRC-1:0]    elig;
   logic [NSRC-1:0]    cand;
   logic [NSRC-1:0]    win_oh;
   logic [NSRC-1:0]    consume;
   logic [NSRC-1:0]    clr_all;
   logic               win_vld;
   logic [CAUSE_W-1:0] win_idx;

   irqarb_gate u_gate (
      .ee_en      (ee_en),
      .crit_en    (crit_en),
      .mchk_en    (mchk_en),
      .hyp_mode   (hyp_mode),
      .prob_state (prob_state),
      .hyp_dec_en (hyp_dec_en),
      .elig       (elig)
   );

   assign cand = pend_q & elig & {NSRC{eval_en}};

   irqarb_pick #(.N(NSRC), .STYLE(PICK_STYLE)) u_pick (
      .req    (cand),
      .valid  (win_vld),
      .idx    (win_idx),
      .onehot (win_oh)
   );

   // Per-source consume rule on take.
   for (genvar i = 0; i < NSRC; i++) begin : g_cons
      if (i == IDX_HDEC) begin : g_keep
         assign consume[i] = 1'b0;
      end else if (i == IDX_DEC) begin : g_dec
         assign consume[i] = dec_clr_on_take;
      end else if (i == IDX_CEXT) begin : g_cext
         assign consume[i] = ~cext_hold;
      end else if (i == IDX_EXT) begin : g_ext
         assign consume[i] = ~ext_hold;
      end else begin : g_drop
         assign consume[i] = 1'b1;
      end
   end

   assign clr_all = (win_oh & consume & {NSRC{win_vld}}) | req_clr;

   irqarb_pend #(.N(NSRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req_set),
      .clr_i  (clr_all),
      .pend_q (pend_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take       <= 1'b0;
         take_cause <= '0;
      end else begin
         take       <= win_vld;
         take_cause <= win_vld ? win_idx : '0;
      end
   end

   assign hard_irq = |pend_q;

   // R12: a take only follows an evaluation
   p_take_after_eval_r12: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(eval_en));

   // R3: the reported cause was pending when it was chosen
   p_winner_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((($past(pend_q) >> take_cause) & NSRC'(1)) != '0));

   // R4: machine check needs its enable
   p_mchk_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cause == CAUSE_W'(IDX_MCHK)) |-> $past(mchk_en));

   // R6: lower-ranked sources need external enable
   p_ee_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cause > CAUSE_W'(IDX_HDEC)) |-> $past(ee_en));

   // R6: critical group also needs critical enable
   p_crit_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cause >= CAUSE_W'(IDX_CEXT) && take_cause <= CAUSE_W'(IDX_CDB))
      |-> $past(crit_en));

   // R5: hypervisor decrementer survives its own take
   p_hdec_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cause == CAUSE_W'(IDX_HDEC) && !$past(req_clr[IDX_HDEC]))
      |-> pend_q[IDX_HDEC]);

   // R8: decrementer survives a take without clear-on-take
   p_dec_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_cause == CAUSE_W'(IDX_DEC) && !$past(dec_clr_on_take)
       && !$past(req_clr[IDX_DEC])) |-> pend_q[IDX_DEC]);

   // R7: always-consumed sources are gone after their take
   p_consumed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && always_consumed(int'(take_cause))
       && ((($past(req_set) >> take_cause) & NSRC'(1)) == '0))
      |-> (((pend_q >> take_cause) & NSRC'(1)) == '0));
endmodule

// File: tb/sim_irq_prio_arbiter.sv
`timescale 1ns/1ps
module sim_irq_prio_arbiter;
   localparam int N = 14;
   localparam logic [N-1:0] M_RST = 14'd1 << 0,  M_MCHK = 14'd1 << 1,
                            M_DBG = 14'd1 << 2,  M_HDEC = 14'd1 << 3,
                            M_CEXT = 14'd1 << 4, M_WDOG = 14'd1 << 5,
                            M_CDB = 14'd1 << 6,  M_FIT = 14'd1 << 7,
                            M_PIT = 14'd1 << 8,  M_DEC = 14'd1 << 9,
                            M_EXT = 14'd1 << 10, M_DB = 14'd1 << 11,
                            M_PERF = 14'd1 << 12, M_THERM = 14'd1 << 13,
                            M_ALL = '1;

   // {set, ee, ce, me, hv, pr, hdec_en, exp_take, exp_cause}
   localparam int NV = 15;
   localparam logic [24:0] VEC [NV] = '{
      {M_ALL,            1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd0},
      {M_MCHK|M_DBG,     1'b1,1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1, 4'd2},
      {M_MCHK|M_DBG,     1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd1},
      {M_HDEC|M_CEXT,    1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1, 4'd4},
      {M_HDEC|M_CEXT,    1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1, 4'd3},
      {M_HDEC,           1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0, 4'd0},
      {M_HDEC,           1'b0,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1, 4'd3},
      {M_CEXT|M_WDOG|M_FIT,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd7},
      {M_WDOG|M_CDB,     1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd5},
      {M_PIT|M_DEC|M_EXT,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd8},
      {M_THERM|M_PERF,   1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd12},
      {M_DB|M_EXT,       1'b0,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0, 4'd0},
      {M_THERM,          1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd13},
      {14'd0,            1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 1'b0, 4'd0},
      {M_HDEC|M_CEXT,    1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 1'b1, 4'd3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] req_set = '0, req_clr = '0;
   logic eval_en = 0, ee_en = 0, crit_en = 0, mchk_en = 0;
   logic hyp_mode = 0, prob_state = 0, hyp_dec_en = 0;
   logic dec_clr_on_take = 1, cext_hold = 0, ext_hold = 0;
   logic take, hard_irq;
   logic [3:0] take_cause;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_prio_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
      .eval_en(eval_en), .ee_en(ee_en), .crit_en(crit_en), .mchk_en(mchk_en),
      .hyp_mode(hyp_mode), .prob_state(prob_state), .hyp_dec_en(hyp_dec_en),
      .dec_clr_on_take(dec_clr_on_take), .cext_hold(cext_hold),
      .ext_hold(ext_hold), .take(take), .take_cause(take_cause),
      .hard_irq(hard_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Drive one cycle's strobes, then sample just after the edge.
   task automatic cyc(input logic [N-1:0] s, input logic [N-1:0] c, input logic ev);
      req_set = s; req_clr = c; eval_en = ev;
      @(posedge clk); #1;
      req_set = '0; req_clr = '0; eval_en = 0;
   endtask

   task automatic flush();
      cyc('0, M_ALL, 0);
   endtask

   task automatic gates(input logic ee, ce, me, hv, pr, hen);
      ee_en = ee; crit_en = ce; mchk_en = me;
      hyp_mode = hv; prob_state = pr; hyp_dec_en = hen;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 take in reset", take, 0);
      chk("R1 hard_irq in reset", hard_irq, 0);
      rst_n = 1;
      @(posedge clk); #1;
      chk("R1 take after reset", take, 0);
      chk("R1 hard_irq after reset", hard_irq, 0);

      // R3 R4 R5 R6: priority table
      for (int v = 0; v < NV; v++) begin
         flush();
         cyc(VEC[v][24:11], '0, 0);
         gates(VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5]);
         cyc('0, '0, 1);
         chk($sformatf("R3 vec %0d take", v), take, int'(VEC[v][4]));
         if (VEC[v][4]) chk($sformatf("R3 vec %0d cause", v), take_cause, int'(VEC[v][3:0]));
      end

      // R2 R10 R11: set beats clear, withdrawal, summary
      flush();
      cyc(M_THERM, M_THERM, 0);
      chk("R2 set beats clear", hard_irq, 1);
      cyc('0, M_THERM, 0);
      chk("R10 withdrawal", hard_irq, 0);

      // R7 R11: consumed source, summary drops
      flush();
      gates(1, 1, 1, 1, 0, 0);
      cyc(M_WDOG, '0, 0);
      chk("R11 pending raises hard_irq", hard_irq, 1);
      cyc('0, '0, 1);
      chk("R7 watchdog cause", take_cause, 5);
      chk("R7 R11 flag consumed", hard_irq, 0);
      cyc('0, '0, 1);
      chk("R7 no retake", take, 0);

      // R12: no evaluation, no take; pulse is one cycle
      flush();
      cyc(M_FIT, '0, 0);
      cyc('0, '0, 0);
      chk("R12 no eval no take", take, 0);
      cyc('0, '0, 1);
      chk("R12 take after eval", take, 1);
      cyc('0, '0, 0);
      chk("R12 pulse ends", take, 0);

      // R8: decrementer conditional clear
      flush();
      dec_clr_on_take = 0;
      cyc(M_DEC, '0, 0);
      cyc('0, '0, 1);
      chk("R8 dec cause", take_cause, 9);
      chk("R8 dec kept", hard_irq, 1);
      cyc('0, '0, 1);
      chk("R8 dec retaken", take, 1);
      dec_clr_on_take = 1;
      cyc('0, '0, 1);
      chk("R8 dec cause 2", take_cause, 9);
      chk("R8 dec cleared", hard_irq, 0);

      // R9: held critical external and external
      flush();
      cext_hold = 1;
      cyc(M_CEXT, '0, 0);
      cyc('0, '0, 1);
      chk("R9 cext cause", take_cause, 4);
      chk("R9 cext held", hard_irq, 1);
      cext_hold = 0;
      cyc('0, '0, 1);
      chk("R9 cext consumed", hard_irq, 0);
      ext_hold = 1;
      cyc(M_EXT, '0, 0);
      cyc('0, '0, 1);
      chk("R9 ext cause", take_cause, 10);
      chk("R9 ext held", hard_irq, 1);
      ext_hold = 0;
      cyc('0, '0, 1);
      chk("R9 ext consumed", hard_irq, 0);

      // R5: hypervisor decrementer kept after take
      flush();
      gates(1, 1, 1, 1, 0, 1);
      cyc(M_HDEC, '0, 0);
      cyc('0, '0, 1);
      chk("R5 hdec cause", take_cause, 3);
      chk("R5 hdec kept", hard_irq, 1);

      // R2: set beats consuming take
      flush();
      cyc(M_WDOG, '0, 0);
      cyc(M_WDOG, '0, 1);
      chk("R2 take with set", take_cause, 5);
      chk("R2 set beats consume", hard_irq, 1);
      cyc('0, '0, 1);
      chk("R2 second take clears", hard_irq, 0);

      // R4: machine check waits for enable
      flush();
      gates(1, 1, 0, 1, 0, 0);
      cyc(M_MCHK, '0, 0);
      cyc('0, '0, 1);
      chk("R4 mchk blocked", take, 0);
      chk("R4 mchk still pending", hard_irq, 1);
      mchk_en = 1;
      cyc('0, '0, 1);
      chk("R4 mchk cause", take_cause, 1);
      chk("R4 mchk consumed", hard_irq, 0);

      // R1: reset mid-run clears pending
      cyc(M_PIT | M_DB, '0, 0);
      rst_n = 0;
      @(posedge clk); #1;
      chk("R1 reset clears hard_irq", hard_irq, 0);
      chk("R1 reset clears take", take, 0);
      rst_n = 1;

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule